// File: doc/BRIEF.md
# Receive FIFO Pause Flow Controller

This block decides when a MAC should ask its link partner to stop and resume sending. It watches the receive FIFO fill level, counted in 64-byte units. When the level climbs above a high-water mark, it requests a stop pause frame. When the level later drops below a separate low-water mark, it requests a resume pause frame. Because the two marks are separate, the block has hysteresis, so a level that hovers near one mark does not produce a stream of frames.

Software can also order a single pause frame with an operand it chooses. In the other direction, the block times pause requests received from the link partner with a 16-bit down-counter. A pause-quantum tick from outside makes the counter count down. While the counter is non-zero, the transmitter is held. Event status bits and the last received pause time are kept for the host. Building and parsing the frames is done elsewhere.

Top module: `rx_pause_flowctl`

## Requirements
- R1: After reset, `pauseReq` is 0, `paused` is 0 and `pauseStatus` is all zero.
- R2: A stop request goes out when all of these hold: send enable (`ctlEnable[0]`) is set, no stop is outstanding, and `fifoLevel > xoffLevel`. The request is a one-cycle `pauseReq` pulse in the cycle after that condition is seen. `pauseReqTime` then equals the operand most recently stored from `sendPauseData[15:0]`.
- R3: A resume request goes out only while a stop is outstanding, and only when `fifoLevel < xonLevel`. It is a one-cycle `pauseReq` with `pauseReqTime` equal to 0, and it clears the outstanding stop.
- R4: Levels between the two marks produce no request. No second stop request is sent while a stop is outstanding, however high the level stays.
- R5: A `sendPauseWr` pulse always stores `sendPauseData[15:0]` as the operand. If bit 16 is also set, a `pauseReq` follows in the next cycle carrying that operand, whatever the enables are. With bit 16 clear, no request follows.
- R6: At most one request is issued per cycle. A software command has priority over a stop request, and a stop request has priority over a resume request. A request that loses stays pending and is issued in a later cycle while its condition still holds.
- R7: While send enable is clear, no threshold-driven request is made. The outstanding-stop state is kept and acted on once send enable returns.
- R8: With receive enable (`ctlEnable[1]`) set, a `rxPauseVld` pulse loads the timer with `rxPauseTime`. `paused` reflects a non-zero loaded value in the next cycle. A received time of 0 ends the paused state in the next cycle.
- R9: Each `quantaTick` lowers a non-zero timer by one, and `paused` drops in the cycle after the tick that brings the timer to 0. A tick on a zero timer has no effect.
- R10: While receive enable is clear, `rxPauseVld` has no effect: `paused` and `pauseStatus` do not change.
- R11: The layout of `pauseStatus` is as follows. Bit 0 records that a pause was accepted. Bit 1 records entry into the paused state. Bit 2 records the return to the not-paused state. Bits 31:16 hold the last accepted pause time, and the other bits read 0. Bits 2:0 are sticky and are cleared by `statusRd`. If an event and `statusRd` fall in the same cycle, the event wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoLevel | input | 11 | Receive FIFO occupancy in 64-byte units |
| xoffLevel | input | 9 | High-water mark for stop requests |
| xonLevel | input | 9 | Low-water mark for resume requests |
| sendPauseWr | input | 1 | Write strobe for the software pause word |
| sendPauseData | input | 17 | [15:0] pause operand, [16] send one frame now |
| ctlEnable | input | 2 | [0] send-pause enable, [1] receive-pause enable |
| quantaTick | input | 1 | One pulse per pause quantum |
| rxPauseVld | input | 1 | A pause frame was received |
| rxPauseTime | input | 16 | Pause time carried by the received frame |
| statusRd | input | 1 | Clears the sticky status bits 2:0 |
| pauseReq | output | 1 | One-cycle request to send a pause frame |
| pauseReqTime | output | 16 | Operand for the requested frame |
| paused | output | 1 | Transmitter hold, high while the timer is non-zero |
| pauseStatus | output | 32 | Event bits and last received pause time |

## Verification
A stuck outstanding-stop flag shows up at the ports during a rising and falling level sweep. The symptom is either a repeated stop request, or a resume that is missing or not requested, and it appears on the first level step that crosses a mark. A wrong timer value shows on `paused` one cycle after the tick or load that exposes it. Because of this, counting ticks from a known load pins the exact cycle at which the hold must drop. Status errors appear in the cycle after the event, both around `statusRd` and when a read and an event coincide.

// File: rtl/rx_pause_pkg.sv
package rx_pause_pkg;
  localparam int TIME_W = 16;

  typedef struct packed {
    logic loadTime;   // store software operand
    logic issueSw;    // software-commanded frame
    logic issueXoff;  // threshold stop frame
    logic issueXon;   // threshold resume frame
    logic loadTimer;  // accepted received pause
    logic decTimer;   // one quantum elapsed
  } ctl_strobes_t;
endpackage

// File: rtl/rx_pause_ctl.sv
module rx_pause_ctl
  import rx_pause_pkg::*;
#(
  parameter int LVL_W = 11,
  parameter int THR_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LVL_W-1:0] fifoLevel,
  input  logic [THR_W-1:0] xoffLevel,
  input  logic [THR_W-1:0] xonLevel,
  input  logic             sendEn,
  input  logic             rxEn,
  input  logic             swWr,
  input  logic             swGo,
  input  logic             rxPauseVld,
  input  logic             quantaTick,
  input  logic             timerZero,
  output ctl_strobes_t     stb
);
  logic xoffSent;
  logic overHigh, underLow;

  assign overHigh = fifoLevel > LVL_W'(xoffLevel);
  assign underLow = fifoLevel < LVL_W'(xonLevel);

  always_comb begin
    stb = '0;
    stb.loadTime = swWr;
    stb.issueSw  = swWr && swGo;
    if (!stb.issueSw) begin
      if (sendEn && !xoffSent && overHigh)
        stb.issueXoff = 1'b1;
      else if (sendEn && xoffSent && underLow)
        stb.issueXon = 1'b1;
    end
    stb.loadTimer = rxPauseVld && rxEn;
    stb.decTimer  = !stb.loadTimer && quantaTick && !timerZero;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               xoffSent <= 1'b0;
    else if (stb.issueXoff)  xoffSent <= 1'b1;
    else if (stb.issueXon)   xoffSent <= 1'b0;
  end

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.issueSw, stb.issueXoff, stb.issueXon})); // R6
  AST_NO_REPEAT_XOFF: assert property (@(posedge clk) disable iff (!rstN)
    stb.issueXoff |=> !stb.issueXoff); // R4
  AST_XON_NOT_TWICE: assert property (@(posedge clk) disable iff (!rstN)
    stb.issueXon |=> !stb.issueXon); // R3
endmodule

// File: rtl/rx_pause_dp.sv
module rx_pause_dp
  import rx_pause_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctl_strobes_t      stb,
  input  logic [TIME_W-1:0] swTime,
  input  logic [TIME_W-1:0] rxPauseTime,
  input  logic              statusRd,
  output logic              pauseReq,
  output logic [TIME_W-1:0] pauseReqTime,
  output logic              timerZero,
  output logic              paused,
  output logic [31:0]       pauseStatus
);
  logic [TIME_W-1:0] timeReg, timer, timerNext, lastTime;
  logic stRcvd, stEnter, stLeave, enterP, leaveP;

  always_comb begin
    timerNext = timer;
    if (stb.loadTimer)     timerNext = rxPauseTime;
    else if (stb.decTimer) timerNext = timer - 1'b1;
  end

  assign timerZero = (timer == '0);
  assign paused    = !timerZero;
  assign enterP    = timerZero && (timerNext != '0);
  assign leaveP    = !timerZero && (timerNext == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeReg      <= '0;
      timer        <= '0;
      lastTime     <= '0;
      pauseReq     <= 1'b0;
      pauseReqTime <= '0;
      stRcvd       <= 1'b0;
      stEnter      <= 1'b0;
      stLeave      <= 1'b0;
    end else begin
      if (stb.loadTime)  timeReg  <= swTime;
      if (stb.loadTimer) lastTime <= rxPauseTime;
      timer    <= timerNext;
      pauseReq <= stb.issueSw || stb.issueXoff || stb.issueXon;
      if (stb.issueSw)        pauseReqTime <= swTime;
      else if (stb.issueXoff) pauseReqTime <= timeReg;
      else                    pauseReqTime <= '0;
      stRcvd  <= stb.loadTimer || (stRcvd  && !statusRd);
      stEnter <= enterP        || (stEnter && !statusRd);
      stLeave <= leaveP        || (stLeave && !statusRd);
    end
  end

  assign pauseStatus = {lastTime, 13'd0, stLeave, stEnter, stRcvd};

  AST_XON_ZERO_TIME: assert property (@(posedge clk) disable iff (!rstN)
    stb.issueXon |=> (pauseReq && pauseReqTime == '0)); // R3
  AST_TIMER_NO_RISE: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadTimer |=> (timer <= $past(timer))); // R9
  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rstN)
    stb.decTimer |=> (timer == $past(timer) - 16'd1)); // R9
  AST_LOAD_PAUSED: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadTimer |=> (paused == ($past(rxPauseTime) != '0))); // R8
endmodule

// File: rtl/rx_pause_flowctl.sv
module rx_pause_flowctl
  import rx_pause_pkg::*;
#(
  parameter int LVL_W = 11,
  parameter int THR_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LVL_W-1:0]  fifoLevel,
  input  logic [THR_W-1:0]  xoffLevel,
  input  logic [THR_W-1:0]  xonLevel,
  input  logic              sendPauseWr,
  input  logic [TIME_W:0]   sendPauseData,
  input  logic [1:0]        ctlEnable,
  input  logic              quantaTick,
  input  logic              rxPauseVld,
  input  logic [TIME_W-1:0] rxPauseTime,
  input  logic              statusRd,
  output logic              pauseReq,
  output logic [TIME_W-1:0] pauseReqTime,
  output logic              paused,
  output logic [31:0]       pauseStatus
);
  ctl_strobes_t stb;
  logic timerZero;

  rx_pause_ctl #(.LVL_W(LVL_W), .THR_W(THR_W)) uCtl (
    .clk(clk), .rstN(rstN), .fifoLevel(fifoLevel),
    .xoffLevel(xoffLevel), .xonLevel(xonLevel),
    .sendEn(ctlEnable[0]), .rxEn(ctlEnable[1]),
    .swWr(sendPauseWr), .swGo(sendPauseData[TIME_W]),
    .rxPauseVld(rxPauseVld), .quantaTick(quantaTick),
    .timerZero(timerZero), .stb(stb)
  );

  rx_pause_dp uDp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .swTime(sendPauseData[TIME_W-1:0]), .rxPauseTime(rxPauseTime),
    .statusRd(statusRd), .pauseReq(pauseReq), .pauseReqTime(pauseReqTime),
    .timerZero(timerZero), .paused(paused), .pauseStatus(pauseStatus)
  );

  AST_RX_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (rxPauseVld && !ctlEnable[1] && !quantaTick && !statusRd)
      |=> ($stable(paused) && $stable(pauseStatus))); // R10
  AST_SW_SEND: assert property (@(posedge clk) disable iff (!rstN)
    (sendPauseWr && sendPauseData[TIME_W])
      |=> (pauseReq && pauseReqTime == $past(sendPauseData[TIME_W-1:0]))); // R5
endmodule

// File: tb/tb_rx_pause_flowctl.sv
module tb_rx_pause_flowctl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [10:0] fifoLevel = '0;
  logic [8:0]  xoffLevel = 9'd8, xonLevel = 9'd3;
  logic        sendPauseWr = 1'b0;
  logic [16:0] sendPauseData = '0;
  logic [1:0]  ctlEnable = 2'b00;
  logic        quantaTick = 1'b0, rxPauseVld = 1'b0, statusRd = 1'b0;
  logic [15:0] rxPauseTime = '0;
  logic        pauseReq, paused;
  logic [15:0] pauseReqTime;
  logic [31:0] pauseStatus;

  int checks = 0, errors = 0;
  bit sent = 1'b0;
  logic [15:0] opnd = '0;

  always #2.5 clk = ~clk;

  rx_pause_flowctl dut (
    .clk(clk), .rstN(rstN), .fifoLevel(fifoLevel), .xoffLevel(xoffLevel),
    .xonLevel(xonLevel), .sendPauseWr(sendPauseWr), .sendPauseData(sendPauseData),
    .ctlEnable(ctlEnable), .quantaTick(quantaTick), .rxPauseVld(rxPauseVld),
    .rxPauseTime(rxPauseTime), .statusRd(statusRd), .pauseReq(pauseReq),
    .pauseReqTime(pauseReqTime), .paused(paused), .pauseStatus(pauseStatus)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  // drive a level for one cycle and check the request against the model
  task automatic levelStep(input int lvl, input string tag);
    logic expReq; logic [15:0] expTime;
    @(negedge clk); fifoLevel = 11'(lvl);
    expReq = 1'b0; expTime = '0;
    if (ctlEnable[0]) begin
      if (!sent && lvl > int'(xoffLevel)) begin expReq = 1'b1; expTime = opnd; sent = 1'b1; end
      else if (sent && lvl < int'(xonLevel)) begin expReq = 1'b1; expTime = '0; sent = 1'b0; end
    end
    cyc();
    chk(tag, {15'd0, pauseReq, pauseReqTime}, {15'd0, expReq, expTime});
  endtask

  task automatic tickCheck(input int remain);
    @(negedge clk); quantaTick = 1'b1;
    cyc();
    @(negedge clk); quantaTick = 1'b0;
    chk("R9 paused after tick", {31'd0, paused}, {31'd0, remain > 0});
  endtask

  initial begin
    #(5 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset req", {31'd0, pauseReq}, 32'd0);
    chk("R1 reset paused", {31'd0, paused}, 32'd0);
    chk("R1 reset status", pauseStatus, 32'd0);
    @(negedge clk); rstN = 1'b1; ctlEnable = 2'b11;

    // store operand without send: no request
    @(negedge clk); sendPauseWr = 1'b1; sendPauseData = {1'b0, 16'h1234};
    cyc(); opnd = 16'h1234;
    @(negedge clk); sendPauseWr = 1'b0;
    chk("R5 store only no req", {31'd0, pauseReq}, 32'd0);

    // hysteresis sweeps with two threshold pairs
    for (int cfg = 0; cfg < 2; cfg++) begin
      xoffLevel = cfg ? 9'd10 : 9'd8;
      xonLevel  = cfg ? 9'd6  : 9'd3;
      for (int pass = 0; pass < 2; pass++) begin
        for (int l = 0; l < 16; l++) levelStep(l, "R2 R4 rising sweep");
        for (int l = 15; l >= 0; l--) levelStep(l, "R3 R4 falling sweep");
      end
    end

    // send disabled: no threshold requests, state held
    ctlEnable = 2'b10;
    for (int l = 0; l < 16; l++) levelStep(l, "R7 disabled rising");
    @(negedge clk); ctlEnable = 2'b11;
    sent = 1'b1;
    levelStep(0, "R7 resume after re-enable"); // XON now due
    levelStep(0, "R4 no repeat");

    // priority: software beats XOFF, XOFF deferred one cycle
    @(negedge clk); fifoLevel = 11'd14; sendPauseWr = 1'b1; sendPauseData = {1'b1, 16'h00AA};
    cyc();
    chk("R6 sw first", {15'd0, pauseReq, pauseReqTime}, {15'd0, 1'b1, 16'h00AA});
    @(negedge clk); sendPauseWr = 1'b0; opnd = 16'h00AA;
    #1; @(posedge clk); #1;
    chk("R6 deferred xoff", {15'd0, pauseReq, pauseReqTime}, {15'd0, 1'b1, 16'h00AA});
    sent = 1'b1;
    levelStep(14, "R4 held high");
    levelStep(0, "R3 xon after xoff");

    // software send while send enable clear
    @(negedge clk); ctlEnable = 2'b10; sendPauseWr = 1'b1; sendPauseData = {1'b1, 16'h0042};
    cyc();
    chk("R5 sw ignores enable", {15'd0, pauseReq, pauseReqTime}, {15'd0, 1'b1, 16'h0042});
    @(negedge clk); sendPauseWr = 1'b0; ctlEnable = 2'b11;

    // receive disabled: ignored
    @(negedge clk); ctlEnable = 2'b01; rxPauseVld = 1'b1; rxPauseTime = 16'd100;
    cyc();
    @(negedge clk); rxPauseVld = 1'b0;
    chk("R10 paused unchanged", {31'd0, paused}, 32'd0);
    chk("R10 status unchanged", pauseStatus, 32'd0);

    // accepted pause and timer countdown
    @(negedge clk); ctlEnable = 2'b11; rxPauseVld = 1'b1; rxPauseTime = 16'd5;
    cyc();
    @(negedge clk); rxPauseVld = 1'b0;
    chk("R8 paused after load", {31'd0, paused}, 32'd1);
    chk("R11 status after load", pauseStatus, {16'd5, 16'h0003});
    @(negedge clk); statusRd = 1'b1;
    cyc();
    @(negedge clk); statusRd = 1'b0;
    chk("R11 cleared by read", pauseStatus, {16'd5, 16'h0000});
    for (int n = 1; n <= 6; n++) tickCheck(5 - n);
    chk("R11 leave bit", pauseStatus, {16'd5, 16'h0004});

    // zero time clears at once
    @(negedge clk); rxPauseVld = 1'b1; rxPauseTime = 16'd7;
    cyc();
    @(negedge clk); rxPauseTime = 16'd0;
    cyc();
    @(negedge clk); rxPauseVld = 1'b0;
    chk("R8 zero clears", {31'd0, paused}, 32'd0);
    chk("R11 status after zero", pauseStatus, {16'd0, 16'h0007});

    // read and event in the same cycle: event wins
    @(negedge clk); statusRd = 1'b1; rxPauseVld = 1'b1; rxPauseTime = 16'd3;
    cyc();
    @(negedge clk); statusRd = 1'b0; rxPauseVld = 1'b0;
    chk("R11 event beats read", pauseStatus, {16'd3, 16'h0003});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule